// File: doc/BRIEF.md
# Timestamped Sample Capture Counter

This block sits in a front-end acquisition module where one clock edge equals one detector sample interval. A single free-running counter does two jobs at once. It is the timestamp attached to every incoming sample, and its low bits are the write address into a circular sample memory. Each sample is therefore stored at a slot that follows directly from its time tag. The bench below runs the clock at 50 MHz. In the target system the same clock runs at 250 MHz, so each count there stands for 4 ns.

A synchronous reset comes in with the distributed clock and clamps the counter at zero. Because reset is sampled only on the sample clock, every board that sees the release on the same edge starts counting on that edge, and the boards stay aligned. During reset the block issues no memory writes. Once reset is released it writes on every clock, wrapping through the buffer. Memory readout, triggering and clock generation live elsewhere.

Top module: `sample_stamp_capture`

## Requirements
- R1: While `rst_i` is low at a rising clock edge, the count grows by exactly one across that edge.
- R2: A rising edge that samples `rst_i` high leaves the count at zero, and it stays there for as long as reset remains high.
- R3: The first cycle with `rst_i` low shows stamp 0, and the first increment happens at the first rising edge that samples `rst_i` low.
- R4: `stamp_o` shows the current count with no added latency. `wr_data_o` carries the stamp in its upper 12 bits, bits 25:14, and the sample in its lower 14 bits, bits 13:0.
- R5: `wr_addr_o` equals the low 10 bits of the current count.
- R6: After address 1023 the write address returns to 0, while the stamp moves on to 1024.
- R7: The 12-bit stamp rolls over from 4095 to 0 without stopping.
- R8: `wr_en_o` is low in any cycle with `rst_i` high and high in every cycle with `rst_i` low.
- R9: Raising reset in the middle of a run returns the count to zero at the next rising edge, whatever its value was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, one rising edge per sample |
| rst_i | input | 1 | Distributed synchronous reset, active high |
| sample_i | input | 14 | Detector sample for the current cycle |
| stamp_o | output | 12 | Timestamp of the current sample |
| wr_addr_o | output | 10 | Circular-buffer write address |
| wr_data_o | output | 26 | Stored word: stamp in the upper bits, sample in the lower bits |
| wr_en_o | output | 1 | Memory write strobe |

## Verification
The vector table tests three reset patterns: a held reset, a clean release followed by counting, and a reset pulse in the middle of a run. These separate a counter that starts one edge early or late from a correct one, and show whether a reset taken partway through actually clears the count. Each sample value in the table is distinct, so a packing or bit-order error in the write word shows up as a mismatch. One long run after release crosses both the address wrap at 1024 and the stamp rollover at 4096, and a truncation error at either width boundary is visible there.

// File: rtl/sample_stamp_pkg.sv
package sample_stamp_pkg;
   localparam int unsigned DEF_CNT_W    = 12;
   localparam int unsigned DEF_ADDR_W   = 10;
   localparam int unsigned DEF_SAMPLE_W = 14;

   function automatic int unsigned word_width(input int unsigned cnt_w,
                                              input int unsigned smp_w,
                                              input bit          keep_stamp);
      return keep_stamp ? (cnt_w + smp_w) : smp_w;
   endfunction
endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] count_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("stamp_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) count_q <= '0;
      else       count_q <= count_q + CNT_W'(1);
   end

   assign count_o = count_q;

   // R2 / R9: a reset sampled at an edge leaves zero behind it
   a_r2_hold_zero: assert property (@(posedge clk_i)
      rst_i |=> (count_q == '0));

   // R1: step of exactly one per edge while running
   a_r1_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rst_i && !$isunknown(count_q)) |=> (count_q == $past(count_q) + CNT_W'(1)));
endmodule

// File: rtl/stamp_write_port.sv
module stamp_write_port
   import sample_stamp_pkg::*;
#(
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned SAMPLE_W   = 14,
   parameter bit          KEEP_STAMP = 1'b1,
   localparam int unsigned WORD_W    = word_width(CNT_W, SAMPLE_W, KEEP_STAMP)
) (
   input  logic                clk_i,
   input  logic                run_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [WORD_W-1:0]   data_o,
   output logic                en_o
);
   if (ADDR_W > CNT_W) begin : g_bad_addr
      $error("stamp_write_port: ADDR_W may not exceed CNT_W");
   end
   if (SAMPLE_W < 1) begin : g_bad_sample
      $error("stamp_write_port: SAMPLE_W must be positive");
   end

   assign addr_o = count_i[ADDR_W-1:0];
   assign en_o   = run_i;

   if (KEEP_STAMP) begin : g_with_stamp
      assign data_o = {count_i, sample_i};
   end else begin : g_sample_only
      assign data_o = sample_i;
   end

   // R6: the address wraps to zero after its top slot
   a_r6_addr_wrap: assert property (@(posedge clk_i) disable iff (!run_i)
      (run_i && addr_o == {ADDR_W{1'b1}}) |=> (!run_i || addr_o == '0));
endmodule

// File: rtl/sample_stamp_capture.sv
module sample_stamp_capture
   import sample_stamp_pkg::*;
#(
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned SAMPLE_W   = DEF_SAMPLE_W,
   parameter bit          KEEP_STAMP = 1'b1,
   localparam int unsigned WORD_W    = word_width(CNT_W, SAMPLE_W, KEEP_STAMP)
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic [CNT_W-1:0]    stamp_o,
   output logic [ADDR_W-1:0]   wr_addr_o,
   output logic [WORD_W-1:0]   wr_data_o,
   output logic                wr_en_o
);
   logic [CNT_W-1:0] count;
   logic             running;

   assign running = !rst_i;

   stamp_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .count_o (count)
   );

   stamp_write_port #(
      .CNT_W      (CNT_W),
      .ADDR_W     (ADDR_W),
      .SAMPLE_W   (SAMPLE_W),
      .KEEP_STAMP (KEEP_STAMP)
   ) u_wport (
      .clk_i    (clk_i),
      .run_i    (running),
      .count_i  (count),
      .sample_i (sample_i),
      .addr_o   (wr_addr_o),
      .data_o   (wr_data_o),
      .en_o     (wr_en_o)
   );

   assign stamp_o = count;

   // R8: no write while reset is high
   a_r8_quiet_in_reset: assert property (@(posedge clk_i)
      rst_i |-> !wr_en_o);

   // R3: the first running cycle after reset carries stamp zero
   a_r3_start_zero: assert property (@(posedge clk_i)
      (rst_i ##1 !rst_i) |-> (stamp_o == '0 && wr_en_o));

   // R5: the write slot follows the stamp
   a_r5_slot_tracks_stamp: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_en_o |-> (wr_addr_o == stamp_o[ADDR_W-1:0]));
endmodule

// File: tb/sample_stamp_capture_tb.sv
module sample_stamp_capture_tb;
   localparam int CW = 12;
   localparam int AW = 10;
   localparam int SW = 14;
   localparam int DW = CW + SW;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [SW-1:0] sample = '0;
   logic [CW-1:0] stamp;
   logic [AW-1:0] waddr;
   logic [DW-1:0] wdata;
   logic          wen;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sample_stamp_capture u_dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .sample_i  (sample),
      .stamp_o   (stamp),
      .wr_addr_o (waddr),
      .wr_data_o (wdata),
      .wr_en_o   (wen)
   );

   // vector: {rst, sample[13:0], expected stamp[11:0]}
   localparam logic [26:0] VEC [NV] = '{
      {1'b1, 14'h0011, 12'd0},   // R2 held
      {1'b1, 14'h0022, 12'd0},   // R2 held
      {1'b0, 14'h2A33, 12'd0},   // R3 first running cycle
      {1'b0, 14'h1544, 12'd1},   // R1
      {1'b0, 14'h3F55, 12'd2},
      {1'b0, 14'h0066, 12'd3},
      {1'b0, 14'h3FFF, 12'd4},
      {1'b1, 14'h0101, 12'd5},   // R9 reset raised, count not yet cleared
      {1'b1, 14'h0202, 12'd0},   // R9 cleared
      {1'b0, 14'h0303, 12'd0},   // R3 restart
      {1'b0, 14'h0404, 12'd1},
      {1'b0, 14'h0505, 12'd2}
   };

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic [SW-1:0] s);
      @(negedge clk);
      rst    = r;
      sample = s;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state after one edge
      @(negedge clk); #1;
      check("R2", "reset stamp", stamp, 0);
      check("R8", "reset wen", wen, 0);

      for (int i = 0; i < NV; i++) begin
         logic          vr;
         logic [SW-1:0] vs;
         logic [CW-1:0] vt;
         {vr, vs, vt} = VEC[i];
         drive(vr, vs);
         check("R1", "stamp", stamp, vt);
         check("R8", "wen", wen, !vr);
         if (!vr) begin
            check("R5", "addr", waddr, vt % 1024);
            check("R4", "data", wdata, {vt, vs});
         end
      end

      // long run across the address wrap and stamp rollover
      drive(1'b1, '0);
      drive(1'b1, '0);
      for (int i = 0; i <= 4097; i++) begin
         logic [SW-1:0] s;
         s = SW'(i * 7);
         drive(1'b0, s);
         if (i == 1023) check("R6", "addr top", waddr, 1023);
         if (i == 1024) begin
            check("R6", "addr wrapped", waddr, 0);
            check("R6", "stamp past wrap", stamp, 1024);
         end
         if (i == 4095) check("R7", "stamp top", stamp, 4095);
         if (i == 4096) begin
            check("R7", "stamp rolled", stamp, 0);
            check("R4", "data after roll", wdata, {12'd0, s});
         end
         if (i == 4097) check("R7", "stamp keeps going", stamp, 1);
         if (!wen) check("R8", "wen while running", wen, 1);
      end

      // reset pulse late in a run clears the count
      drive(1'b1, '0);
      check("R8", "wen at reset", wen, 0);
      drive(1'b0, 14'h1234);
      check("R9", "stamp after pulse", stamp, 0);
      check("R4", "data after pulse", wdata, {12'd0, 14'h1234});
      finish_run();
   end
endmodule